// File: doc/BRIEF.md
# Processor Power-On Reset Sequencer

This block brings a processor subsystem out of reset at power-up in a fixed, closed-loop order. It runs on a free-running reference clock. A power-good input acts as its master reset. Once power is good, it lets the main PLL out of reset so the PLL can start in bypass and clock the subsystem. After a settle interval it releases the always-on interrupt-controller reset.

It then watches the processor clock. A toggle flop in that domain is sampled from the reference clock, and a set number of observed edges counts as proof that the clock is running. Only after that proof does it release the processor power-on reset. That release is synchronized to the processor clock. The sequence ends when the subsystem returns a reset-done indication.

If reset-done is late, a sticky timeout flag is raised and the sequencer keeps waiting. Dropping power-good at any time clears every output at once and restarts the sequence from the beginning. All control pins are plain levels: the block moves no data, so it has no valid/ready interface.

Top module: `por_seq_top`

## Requirements
- R1: While `pwr_good` is low, `pll_rst_n`, `aon_rst_n`, `cpu_por_n`, `seq_done` and `done_timeout` are all low, and they go low without waiting for a clock edge when `pwr_good` falls.
- R2: After `pwr_good` rises, `pll_rst_n` is the first output to go high, on the third `clk_ref` rising edge (default `SYNC_STAGES` = 2). `aon_rst_n` is still low at that point.
- R3: `aon_rst_n` goes high exactly `PLL_SETTLE` `clk_ref` cycles after `pll_rst_n` goes high.
- R4: `cpu_por_n` stays low until `MIN_EDGES` processor-clock rising edges have been observed after `aon_rst_n` was released. With `cpu_clk` stopped it never goes high.
- R5: The rising edge of `cpu_por_n` coincides with a rising edge of `cpu_clk`.
- R6: In the waiting state, `seq_done` goes high on the third `clk_ref` rising edge after `rst_done` is first sampled high, and it then stays high while power is good.
- R7: If `rst_done` has not arrived `DONE_TIMEOUT` `clk_ref` cycles after the power-on reset release, `done_timeout` goes high and stays high. `seq_done` stays low, and a later `rst_done` still completes the sequence.
- R8: A `pwr_good` drop in the middle of the sequence restarts it: the next rise of `pwr_good` repeats the full release order from the PLL step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| pwr_good | input | 1 | Power good; low acts as asynchronous reset of the whole sequence |
| cpu_clk | input | 1 | Processor clock whose activity is checked |
| rst_done | input | 1 | Reset-done indication from the subsystem (asynchronous) |
| pll_rst_n | output | 1 | Main PLL reset, active low |
| aon_rst_n | output | 1 | Always-on interrupt controller reset, active low |
| cpu_por_n | output | 1 | Processor power-on reset, active low, released on `cpu_clk` |
| seq_done | output | 1 | Sequence complete |
| done_timeout | output | 1 | Sticky flag: reset-done was late |

## Verification
Each result has a fixed due cycle:
- The PLL release appears on the third reference edge after `pwr_good` rises.
- The always-on release follows exactly `PLL_SETTLE` reference cycles after that.
- `seq_done` rises on the third reference edge after `rst_done` is driven.
- The power-drop clear appears within a nanosecond, with no clock edge.

The bench drives inputs on falling reference edges and samples one falling edge after each due edge, so every result is checked in the cycle it is due. The release order is scored against a queue of expected events. The processor-clock alignment of `cpu_por_n` is checked against the time of the last `cpu_clk` rising edge.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_PLL    = 3'd1,
    ST_AON    = 3'd2,
    ST_CLKCHK = 3'd3,
    ST_WAIT   = 3'd4,
    ST_DONE   = 3'd5
  } seq_st_e;
endpackage

// File: rtl/por_rst_sync.sv
module por_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  // asserts immediately, releases after STAGES edges of clk
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/por_clk_mon.sv
module por_clk_mon #(
  parameter int MIN_EDGES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic cpu_clk,
  input  logic cnt_en,
  output logic running
);
  localparam int CW = $clog2(MIN_EDGES + 1);
  localparam int SW = SYNC_STAGES + 1;

  logic          tgl_q;
  logic [SW-1:0] smp_q;
  logic [CW-1:0] cnt_q;
  logic          edge_seen;

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= ~tgl_q;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= {smp_q[SW-2:0], tgl_q};
  end

  assign edge_seen = smp_q[SW-1] ^ smp_q[SW-2];

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)                                 cnt_q <= '0;
    else if (!cnt_en)                           cnt_q <= '0;
    else if (edge_seen && (cnt_q != CW'(MIN_EDGES))) cnt_q <= cnt_q + 1'b1;
  end

  assign running = (cnt_q == CW'(MIN_EDGES));

  // R4: count never exceeds the threshold
  cnt_bound_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cnt_q <= CW'(MIN_EDGES));
endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_seq_pkg::*;
#(
  parameter int PLL_SETTLE   = 8,
  parameter int DONE_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_running,
  input  logic rst_done,
  output logic pll_rel,
  output logic aon_rel,
  output logic por_rel,
  output logic chk_en,
  output logic seq_done,
  output logic err
);
  localparam int PW = $clog2(PLL_SETTLE + 1);
  localparam int TW = $clog2(DONE_TIMEOUT + 1);

  seq_st_e       st_q, st_d;
  logic [PW-1:0] set_cnt_q;
  logic [TW-1:0] tmo_cnt_q;
  logic [1:0]    done_s_q;
  logic          done_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_s_q <= '0;
    else        done_s_q <= {done_s_q[0], rst_done};
  end
  assign done_s = done_s_q[1];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HOLD:   st_d = ST_PLL;
      ST_PLL:    if (set_cnt_q == PW'(PLL_SETTLE - 1)) st_d = ST_AON;
      ST_AON:    st_d = ST_CLKCHK;
      ST_CLKCHK: if (clk_running) st_d = ST_WAIT;
      ST_WAIT:   if (done_s) st_d = ST_DONE;
      ST_DONE:   st_d = ST_DONE;
      default:   st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HOLD;
      set_cnt_q <= '0;
      tmo_cnt_q <= '0;
      err       <= 1'b0;
      pll_rel   <= 1'b0;
      aon_rel   <= 1'b0;
      por_rel   <= 1'b0;
    end else begin
      st_q    <= st_d;
      pll_rel <= (st_d != ST_HOLD);
      aon_rel <= (st_d == ST_AON) || (st_d == ST_CLKCHK) ||
                 (st_d == ST_WAIT) || (st_d == ST_DONE);
      por_rel <= (st_d == ST_WAIT) || (st_d == ST_DONE);
      if (st_q == ST_PLL) set_cnt_q <= set_cnt_q + 1'b1;
      if (st_q == ST_WAIT && tmo_cnt_q != TW'(DONE_TIMEOUT)) begin
        tmo_cnt_q <= tmo_cnt_q + 1'b1;
        if (tmo_cnt_q == TW'(DONE_TIMEOUT - 1)) err <= 1'b1;
      end
    end
  end

  assign chk_en   = (st_q == ST_CLKCHK);
  assign seq_done = (st_q == ST_DONE);

  // R4: power-on reset release only follows a proven clock
  clock_proven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_rel) |-> $past(clk_running));

  // R2
  aon_after_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aon_rel |-> pll_rel);

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> seq_done);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R6
  done_needs_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> por_rel);
endmodule

// File: rtl/por_seq_top.sv
module por_seq_top #(
  parameter int SYNC_STAGES  = 2,
  parameter int PLL_SETTLE   = 8,
  parameter int MIN_EDGES    = 4,
  parameter int DONE_TIMEOUT = 64
) (
  input  logic clk_ref,
  input  logic pwr_good,
  input  logic cpu_clk,
  input  logic rst_done,
  output logic pll_rst_n,
  output logic aon_rst_n,
  output logic cpu_por_n,
  output logic seq_done,
  output logic done_timeout
);
  logic pll_rel, aon_rel, por_rel, chk_en, clk_running;

  por_seq_fsm #(.PLL_SETTLE(PLL_SETTLE), .DONE_TIMEOUT(DONE_TIMEOUT)) u_fsm (
    .clk(clk_ref), .rst_n(pwr_good), .clk_running(clk_running),
    .rst_done(rst_done), .pll_rel(pll_rel), .aon_rel(aon_rel),
    .por_rel(por_rel), .chk_en(chk_en), .seq_done(seq_done),
    .err(done_timeout));

  por_clk_mon #(.MIN_EDGES(MIN_EDGES), .SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_ref(clk_ref), .rst_n(pwr_good), .cpu_clk(cpu_clk),
    .cnt_en(chk_en), .running(clk_running));

  por_rst_sync #(.STAGES(SYNC_STAGES)) u_pll_sync (
    .clk(clk_ref), .arst_n(pll_rel), .srst_n(pll_rst_n));

  por_rst_sync #(.STAGES(SYNC_STAGES)) u_aon_sync (
    .clk(clk_ref), .arst_n(aon_rel), .srst_n(aon_rst_n));

  por_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(cpu_clk), .arst_n(por_rel), .srst_n(cpu_por_n));

  // R2
  aon_order_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    aon_rst_n |-> pll_rst_n);

  // R4
  por_order_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    cpu_por_n |-> aon_rst_n);

  // R6
  done_after_por_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    seq_done |-> cpu_por_n);
endmodule

// File: tb/por_seq_top_tb.sv
`timescale 1ns/100ps
module por_seq_top_tb;
  localparam int PLL_SETTLE = 8;
  localparam int DONE_TIMEOUT = 64;

  logic clk_ref = 0, cpu_clk = 0, cpu_clk_en = 1;
  logic pwr_good = 0, rst_done = 0;
  logic pll_rst_n, aon_rst_n, cpu_por_n, seq_done, done_timeout;

  int n_tests = 0, n_fail = 0, cyc = 0, pll_cyc = 0;
  int exp_q[$];
  realtime last_cpu = 0;
  logic p_pll = 0, p_aon = 0, p_por = 0, p_done = 0;

  por_seq_top #(.PLL_SETTLE(PLL_SETTLE), .DONE_TIMEOUT(DONE_TIMEOUT)) u_dut (
    .clk_ref(clk_ref), .pwr_good(pwr_good), .cpu_clk(cpu_clk),
    .rst_done(rst_done), .pll_rst_n(pll_rst_n), .aon_rst_n(aon_rst_n),
    .cpu_por_n(cpu_por_n), .seq_done(seq_done), .done_timeout(done_timeout));

  always #2.5 clk_ref = ~clk_ref;
  initial forever begin
    #3.5;
    if (cpu_clk_en) cpu_clk = ~cpu_clk;
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sb_pop(int id);
    if (exp_q.size() == 0) check(0, "R2 order (unexpected release)", id, 0);
    else begin
      int e;
      e = exp_q.pop_front();
      check(e == id, "R2/R8 release order", id, e);
    end
  endtask

  // monitor: release events 1=pll 2=aon 3=por 4=done
  always @(negedge clk_ref) begin
    cyc++;
    if (pll_rst_n && !p_pll) begin sb_pop(1); pll_cyc = cyc; end
    if (aon_rst_n && !p_aon) begin
      sb_pop(2);
      check(cyc - pll_cyc == PLL_SETTLE, "R3 settle gap", cyc - pll_cyc, PLL_SETTLE);
    end
    if (cpu_por_n && !p_por) sb_pop(3);
    if (seq_done && !p_done) sb_pop(4);
    p_pll = pll_rst_n; p_aon = aon_rst_n; p_por = cpu_por_n; p_done = seq_done;
  end

  always @(posedge cpu_clk) last_cpu = $realtime;
  always @(posedge cpu_por_n)
    if (pwr_good)
      check(($realtime - last_cpu) < 0.5, "R5 por aligned to cpu_clk",
            int'($realtime - last_cpu), 0);

  task automatic ncyc(int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic wait_por(int lim);
    int k = 0;
    while (!cpu_por_n && k < lim) begin @(negedge clk_ref); k++; end
    check(cpu_por_n, "R4 por eventually released", cpu_por_n, 1);
  endtask

  task automatic all_low(string req);
    check({pll_rst_n, aon_rst_n, cpu_por_n, seq_done, done_timeout} == 5'b0,
          req, {pll_rst_n, aon_rst_n, cpu_por_n, seq_done, done_timeout}, 0);
  endtask

  task automatic drive_done_check(bit exp_err);
    exp_q.push_back(4);
    rst_done = 1;
    @(posedge clk_ref); @(posedge clk_ref); @(negedge clk_ref);
    check(!seq_done, "R6 done not before third edge", seq_done, 0);
    @(negedge clk_ref);
    check(seq_done, "R6 done on third edge", seq_done, 1);
    check(done_timeout == exp_err, "R7 timeout flag", done_timeout, exp_err);
    ncyc(5);
    check(seq_done, "R6 done stays high", seq_done, 1);
  endtask

  initial begin
    ncyc(4);
    all_low("R1 reset state");
    // normal sequence
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
    pwr_good = 1;
    @(posedge clk_ref); @(posedge clk_ref); @(negedge clk_ref);
    check(!pll_rst_n, "R2 pll not before third edge", pll_rst_n, 0);
    @(negedge clk_ref);
    check(pll_rst_n && !aon_rst_n, "R2 pll first", {pll_rst_n, aon_rst_n}, 2);
    wait_por(300);
    ncyc(5);
    drive_done_check(0);
    // power drop
    @(negedge clk_ref);
    pwr_good = 0; rst_done = 0;
    #1 all_low("R1 async clear on power drop");
    ncyc(3);
    // restart, drop mid-sequence
    exp_q.push_back(1);
    pwr_good = 1;
    ncyc(4);
    check(pll_rst_n && !aon_rst_n, "R8 restart from pll step", {pll_rst_n, aon_rst_n}, 2);
    pwr_good = 0;
    #1 all_low("R8 mid-sequence drop clears");
    ncyc(3);
    // stopped processor clock, then late done
    cpu_clk_en = 0;
    exp_q.push_back(1); exp_q.push_back(2);
    pwr_good = 1;
    ncyc(100);
    check(aon_rst_n && !cpu_por_n, "R4 no por without clock", {aon_rst_n, cpu_por_n}, 2);
    exp_q.push_back(3);
    cpu_clk_en = 1;
    wait_por(300);
    ncyc(20);
    check(!done_timeout, "R7 no early timeout", done_timeout, 0);
    ncyc(DONE_TIMEOUT + 10);
    check(done_timeout && !seq_done, "R7 timeout set, still waiting",
          {done_timeout, seq_done}, 2);
    drive_done_check(1);
    check(exp_q.size() == 0, "R8 all expected releases seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule